// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Control

This block is the software-visible register bank of a serial port. A processor reaches it over a simple 32-bit register bus that carries an address, a write strobe with write data and a read strobe with read data. The bank keeps the line settings, the control word, the integer and fractional baud divisors, the low-power divisor, the FIFO level selection and the DMA control word. The transmit shifter, the baud timing, the receive FIFO and the DMA handshakes sit outside it and connect through plain signals. A write to the data register hands a byte to the transmitter. A read of the data register pops the head of the receive FIFO.

Interrupts are held in a raw status word. A data-register write sets the transmit bit. A receive pulse from the FIFO logic sets the receive bit. Software writes a mask, reads the raw or the masked view, and clears raw bits by writing ones to a separate clear register. One level interrupt output is registered from the masked status. Eight identification bytes can be read from the top eight words of the 4 KB window. Any access to an offset that is not decoded returns zero, changes nothing and raises a one-cycle error pulse.

Top module: `uart_regbank`

## Requirements
- R1: After reset these registers hold their reset values: control reads 0x300, FIFO level select reads 0x12, flags read 0x90, and mask, raw status and DMA control read 0. The `irq` and `bus_err` outputs are low.
- R2: A write to word 0 (byte offset 0x000) drives `tx_valid` high in the same cycle, with `tx_byte` equal to write-data bits 7:0. From the next clock edge the raw status reads with bit 5 set.
- R3: A high cycle on `rx_evt` sets raw status bit 4 at the next edge. If the same cycle also writes a 1 to that bit through the clear register, the set takes priority and the bit stays 1.
- R4: A write to the clear register (offset 0x044) clears each raw status bit whose written bit is 1. All other raw bits keep their value.
- R5: A write to the mask register (offset 0x038) replaces the mask. The masked status (offset 0x040) reads raw AND mask. `irq` is high, one clock edge after the cause, whenever that AND is nonzero.
- R6: The configuration registers read back the written value cut to their widths: low-power divisor at 0x020 (8 bits), integer divisor at 0x024 (16 bits), fractional divisor at 0x028 (6 bits), line control at 0x02C (8 bits), control at 0x030 (16 bits), FIFO level at 0x034 (6 bits) and DMA control at 0x048 (3 bits).
- R7: A bus write to the flags register (offset 0x018) has no effect. A high cycle on `flag_upd` loads `flag_val` into the flags register.
- R8: Reads at byte offsets 0xFE0 through 0xFFC return, one per word in rising address order, the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: A read of an offset that is not readable, or a write to an offset that is not writable, returns zero. No register changes. `bus_err` is high for exactly the one cycle after the access. Raw and masked status are read-only, and the clear register and the identification window are write-only and read-only respectively.
- R10: A write to DMA control with bit 0 or bit 1 set stores the value and pulses `dma_unsup` for one cycle after the write.
- R11: A read of word 0 returns `rx_head` (12 bits) and pulses `rx_pop` in that cycle. A read of word 1 (offset 0x004) returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| bus_err | output | 1 | One-cycle pulse after an access to an offset that is not decoded |
| tx_byte | output | 8 | Byte written to the data register |
| tx_valid | output | 1 | Data-register write in this cycle |
| rx_head | input | 12 | Word at the head of the receive FIFO |
| rx_pop | output | 1 | Data-register read in this cycle |
| rx_evt | input | 1 | Receive interrupt event pulse |
| flag_upd | input | 1 | Load strobe for the flags register |
| flag_val | input | 9 | New flags value |
| dma_unsup | output | 1 | Pulse after a DMA-enable write |
| irq | output | 1 | Registered level interrupt |

## Verification
On every cycle, the assertions check four things: the interrupt level against the stored raw and mask words, the set of the status bits after a transmit write or a receive pulse, that bus writes do not move the flags, and that the error and DMA pulses follow their causes. The bench scenarios alone cover the following: readback width truncation, the identification byte order, reset values, and the set-beats-clear priority seen through the status read. They also cover the proof that a rejected access leaves the mask and status words unchanged.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int NREG     = 19;

    localparam int IDX_DATA = 0;
    localparam int IDX_RSR  = 1;
    localparam int IDX_FLAG = 6;
    localparam int IDX_ILPR = 8;
    localparam int IDX_IBRD = 9;
    localparam int IDX_FBRD = 10;
    localparam int IDX_LCR  = 11;
    localparam int IDX_CR   = 12;
    localparam int IDX_IFLS = 13;
    localparam int IDX_MASK = 14;
    localparam int IDX_RAW  = 15;
    localparam int IDX_MIS  = 16;
    localparam int IDX_CLR  = 17;
    localparam int IDX_DMA  = 18;

    localparam int IRQ_W  = 11;
    localparam int IRQ_TX = 5;
    localparam int IRQ_RX = 4;

    localparam int ILPR_W = 8;
    localparam int IBRD_W = 16;
    localparam int FBRD_W = 6;
    localparam int LCR_W  = 8;
    localparam int CR_W   = 16;
    localparam int IFLS_W = 6;
    localparam int DMA_W  = 3;
    localparam int FLAG_W = 9;
    localparam int RXD_W  = 12;
    localparam int TXD_W  = 8;

    localparam int ID_N   = 8;
    localparam int ID_SW  = $clog2(ID_N);

    localparam logic [CR_W-1:0]   CR_RST   = 16'h0300;
    localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;
    localparam logic [FLAG_W-1:0] FLAG_RST = 9'h090;

    function automatic logic [7:0] id_byte(input logic [ID_SW-1:0] sel);
        logic [7:0] b;
        case (sel)
            3'd0:    b = 8'h11;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    function automatic bit can_read(input int idx);
        return (idx == IDX_DATA) || (idx == IDX_RSR) || (idx == IDX_FLAG) ||
               ((idx >= IDX_ILPR) && (idx <= IDX_MIS)) || (idx == IDX_DMA);
    endfunction

    function automatic bit can_write(input int idx);
        return (idx == IDX_DATA) || (idx == IDX_RSR) || (idx == IDX_FLAG) ||
               ((idx >= IDX_ILPR) && (idx <= IDX_MASK)) ||
               (idx == IDX_CLR) || (idx == IDX_DMA);
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [NREG-1:0]   rd_sel,
    output logic [NREG-1:0]   wr_sel,
    output logic              id_hit,
    output logic [ID_SW-1:0]  id_sel,
    output logic              err_o
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int ID_LO  = (1 << IDX_W) - ID_N;

    typedef struct packed {
        logic err;
    } dec_t;

    logic [IDX_W-1:0] idx;
    logic             rd_ok;
    logic             wr_ok;
    dec_t             st_d, st_q;

    assign idx = addr[ADDR_W-1:2];

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        localparam bit RD_OK = can_read(g);
        localparam bit WR_OK = can_write(g);
        assign rd_sel[g] = RD_OK && rd && (idx == IDX_W'(g));
        assign wr_sel[g] = WR_OK && wr && (idx == IDX_W'(g));
    end

    assign id_hit = rd && (idx >= IDX_W'(ID_LO));
    assign id_sel = idx[ID_SW-1:0];
    assign rd_ok  = (|rd_sel) || id_hit;
    assign wr_ok  = |wr_sel;

    always_comb begin
        st_d     = st_q;
        st_d.err = (rd && !rd_ok) || (wr && !wr_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    assert_err_follows_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rd || wr));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(rd || wr, 1)) |-> 1'b0) else $error("err without access");

endmodule

// File: rtl/uart_rb_cfg.sv
module uart_rb_cfg
    import uart_rb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag_upd,
    input  logic [FLAG_W-1:0] flag_val,
    output logic [ILPR_W-1:0] ilpr,
    output logic [IBRD_W-1:0] ibrd,
    output logic [FBRD_W-1:0] fbrd,
    output logic [LCR_W-1:0]  lcr,
    output logic [CR_W-1:0]   cr,
    output logic [IFLS_W-1:0] ifls,
    output logic [DMA_W-1:0]  dma,
    output logic [FLAG_W-1:0] flags,
    output logic              dma_unsup
);

    typedef struct packed {
        logic [ILPR_W-1:0] ilpr;
        logic [IBRD_W-1:0] ibrd;
        logic [FBRD_W-1:0] fbrd;
        logic [LCR_W-1:0]  lcr;
        logic [CR_W-1:0]   cr;
        logic [IFLS_W-1:0] ifls;
        logic [DMA_W-1:0]  dma;
        logic [FLAG_W-1:0] flags;
        logic              unsup;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.unsup = 1'b0;
        if (wr_sel[IDX_ILPR]) st_d.ilpr = wdata[ILPR_W-1:0];
        if (wr_sel[IDX_IBRD]) st_d.ibrd = wdata[IBRD_W-1:0];
        if (wr_sel[IDX_FBRD]) st_d.fbrd = wdata[FBRD_W-1:0];
        if (wr_sel[IDX_LCR])  st_d.lcr  = wdata[LCR_W-1:0];
        if (wr_sel[IDX_CR])   st_d.cr   = wdata[CR_W-1:0];
        if (wr_sel[IDX_IFLS]) st_d.ifls = wdata[IFLS_W-1:0];
        if (wr_sel[IDX_DMA]) begin
            st_d.dma   = wdata[DMA_W-1:0];
            st_d.unsup = |wdata[1:0];
        end
        // bus writes to the flags word are dropped; only the status strobe loads it
        if (flag_upd) st_d.flags = flag_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cr    <= CR_RST;
            st_q.ifls  <= IFLS_RST;
            st_q.flags <= FLAG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ilpr      = st_q.ilpr;
    assign ibrd      = st_q.ibrd;
    assign fbrd      = st_q.fbrd;
    assign lcr       = st_q.lcr;
    assign cr        = st_q.cr;
    assign ifls      = st_q.ifls;
    assign dma       = st_q.dma;
    assign flags     = st_q.flags;
    assign dma_unsup = st_q.unsup;

    assert_flags_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[IDX_FLAG] && !flag_upd) |=> $stable(flags));

    assert_dma_unsup_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[IDX_DMA] && (wdata[1:0] != 2'b00)) |=> dma_unsup);

    assert_dma_unsup_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_unsup |-> $past(wr_sel[IDX_DMA]));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  wr_sel,
    input  logic [IRQ_W-1:0] wdata,
    input  logic             rx_evt,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);

    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_t;

    irq_t             st_d, st_q;
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] clr_v;

    always_comb begin
        set_v         = '0;
        set_v[IRQ_TX] = wr_sel[IDX_DATA];
        set_v[IRQ_RX] = rx_evt;
        clr_v         = wr_sel[IDX_CLR] ? wdata : '0;

        st_d      = st_q;
        // a set arriving with a clear of the same bit wins so no event is lost
        st_d.raw  = (st_q.raw & ~clr_v) | set_v;
        if (wr_sel[IDX_MASK]) st_d.mask = wdata;
        st_d.irq  = |(st_d.raw & st_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw & mask) != '0));

    assert_tx_sets_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[IDX_DATA] |=> raw[IRQ_TX]);

    assert_rx_sets_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> raw[IRQ_RX]);

    assert_clear_drops_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[IDX_CLR] && wdata[IRQ_TX] && !wr_sel[IDX_DATA]) |=> !raw[IRQ_TX]);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [TXD_W-1:0]  tx_byte,
    output logic              tx_valid,
    input  logic [RXD_W-1:0]  rx_head,
    output logic              rx_pop,
    input  logic              rx_evt,
    input  logic              flag_upd,
    input  logic [FLAG_W-1:0] flag_val,
    output logic              dma_unsup,
    output logic              irq
);

    logic [NREG-1:0]   rd_sel;
    logic [NREG-1:0]   wr_sel;
    logic              id_hit;
    logic [ID_SW-1:0]  id_sel;
    logic [ILPR_W-1:0] ilpr;
    logic [IBRD_W-1:0] ibrd;
    logic [FBRD_W-1:0] fbrd;
    logic [LCR_W-1:0]  lcr;
    logic [CR_W-1:0]   cr;
    logic [IFLS_W-1:0] ifls;
    logic [DMA_W-1:0]  dma;
    logic [FLAG_W-1:0] flags;
    logic [IRQ_W-1:0]  raw;
    logic [IRQ_W-1:0]  mask;

    uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel),
        .id_hit (id_hit),
        .id_sel (id_sel),
        .err_o  (bus_err)
    );

    uart_rb_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .wdata     (bus_wdata),
        .flag_upd  (flag_upd),
        .flag_val  (flag_val),
        .ilpr      (ilpr),
        .ibrd      (ibrd),
        .fbrd      (fbrd),
        .lcr       (lcr),
        .cr        (cr),
        .ifls      (ifls),
        .dma       (dma),
        .flags     (flags),
        .dma_unsup (dma_unsup)
    );

    uart_rb_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wdata  (bus_wdata[IRQ_W-1:0]),
        .rx_evt (rx_evt),
        .raw    (raw),
        .mask   (mask),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (id_hit)                 bus_rdata = DATA_W'(id_byte(id_sel));
        else if (rd_sel[IDX_DATA])  bus_rdata = DATA_W'(rx_head);
        else if (rd_sel[IDX_FLAG])  bus_rdata = DATA_W'(flags);
        else if (rd_sel[IDX_ILPR])  bus_rdata = DATA_W'(ilpr);
        else if (rd_sel[IDX_IBRD])  bus_rdata = DATA_W'(ibrd);
        else if (rd_sel[IDX_FBRD])  bus_rdata = DATA_W'(fbrd);
        else if (rd_sel[IDX_LCR])   bus_rdata = DATA_W'(lcr);
        else if (rd_sel[IDX_CR])    bus_rdata = DATA_W'(cr);
        else if (rd_sel[IDX_IFLS])  bus_rdata = DATA_W'(ifls);
        else if (rd_sel[IDX_MASK])  bus_rdata = DATA_W'(mask);
        else if (rd_sel[IDX_RAW])   bus_rdata = DATA_W'(raw);
        else if (rd_sel[IDX_MIS])   bus_rdata = DATA_W'(raw & mask);
        else if (rd_sel[IDX_DMA])   bus_rdata = DATA_W'(dma);
    end

    assign tx_valid = wr_sel[IDX_DATA];
    assign tx_byte  = bus_wdata[TXD_W-1:0];
    assign rx_pop   = rd_sel[IDX_DATA];

    assert_rx_pop_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_rd && !bus_wr));

    assert_err_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !id_hit && (rd_sel == '0)) |-> (bus_rdata == '0));

endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic [11:0] rx_head = '0;
    logic        rx_pop;
    logic        rx_evt = 1'b0;
    logic        flag_upd = 1'b0;
    logic [8:0]  flag_val = '0;
    logic        dma_unsup;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .rx_head(rx_head), .rx_pop(rx_pop), .rx_evt(rx_evt),
        .flag_upd(flag_upd), .flag_val(flag_val), .dma_unsup(dma_unsup), .irq(irq)
    );

    // op: 0 write, 1 read and compare, 2 compare irq level
    localparam int NV = 41;
    localparam logic [77:0] VEC [NV] = '{
        {2'd1, 12'h030, 32'h0, 32'h0000_0300},
        {2'd1, 12'h034, 32'h0, 32'h0000_0012},
        {2'd1, 12'h018, 32'h0, 32'h0000_0090},
        {2'd1, 12'h038, 32'h0, 32'h0000_0000},
        {2'd1, 12'h03C, 32'h0, 32'h0000_0000},
        {2'd1, 12'h048, 32'h0, 32'h0000_0000},
        {2'd0, 12'h024, 32'hFFFF_1234, 32'h0},
        {2'd1, 12'h024, 32'h0, 32'h0000_1234},
        {2'd0, 12'h028, 32'h0000_00FF, 32'h0},
        {2'd1, 12'h028, 32'h0, 32'h0000_003F},
        {2'd0, 12'h020, 32'h0000_01AB, 32'h0},
        {2'd1, 12'h020, 32'h0, 32'h0000_00AB},
        {2'd0, 12'h02C, 32'h0000_0070, 32'h0},
        {2'd1, 12'h02C, 32'h0, 32'h0000_0070},
        {2'd0, 12'h030, 32'h0001_2345, 32'h0},
        {2'd1, 12'h030, 32'h0, 32'h0000_2345},
        {2'd0, 12'h034, 32'h0000_002D, 32'h0},
        {2'd1, 12'h034, 32'h0, 32'h0000_002D},
        {2'd0, 12'h018, 32'h0000_0000, 32'h0},
        {2'd1, 12'h018, 32'h0, 32'h0000_0090},
        {2'd1, 12'h004, 32'h0, 32'h0000_0000},
        {2'd1, 12'hFE0, 32'h0, 32'h0000_0011},
        {2'd1, 12'hFE4, 32'h0, 32'h0000_0010},
        {2'd1, 12'hFE8, 32'h0, 32'h0000_0014},
        {2'd1, 12'hFEC, 32'h0, 32'h0000_0000},
        {2'd1, 12'hFF0, 32'h0, 32'h0000_000D},
        {2'd1, 12'hFF4, 32'h0, 32'h0000_00F0},
        {2'd1, 12'hFF8, 32'h0, 32'h0000_0005},
        {2'd1, 12'hFFC, 32'h0, 32'h0000_00B1},
        {2'd0, 12'h000, 32'h0000_0041, 32'h0},
        {2'd1, 12'h03C, 32'h0, 32'h0000_0020},
        {2'd1, 12'h040, 32'h0, 32'h0000_0000},
        {2'd2, 12'h000, 32'h0, 32'h0000_0000},
        {2'd0, 12'h038, 32'h0000_0030, 32'h0},
        {2'd1, 12'h040, 32'h0, 32'h0000_0020},
        {2'd2, 12'h000, 32'h0, 32'h0000_0001},
        {2'd0, 12'h044, 32'h0000_0020, 32'h0},
        {2'd1, 12'h03C, 32'h0, 32'h0000_0000},
        {2'd2, 12'h000, 32'h0, 32'h0000_0000},
        {2'd0, 12'h048, 32'h0000_0004, 32'h0},
        {2'd1, 12'h048, 32'h0, 32'h0000_0004}
    };

    function automatic string req_of(input logic [1:0] op, input logic [11:0] a, input int i);
        if (i < 6)            return "R1 reset value";
        if (op == 2'd2)       return "R5 irq level";
        if (a >= 12'hFE0)     return "R8 id byte";
        if (a == 12'h018)     return "R7 flags";
        if (a == 12'h004)     return "R11 status word";
        if (a == 12'h03C && i < 33) return "R2 tx raw bit";
        if (a == 12'h040)     return "R5 masked view";
        if (a == 12'h03C)     return "R4 clear";
        return "R6 readback";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 err after reset", {31'b0, bus_err}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            if (op == 2'd0) wr(a, d);
            else if (op == 2'd1) begin
                rd(a, v);
                check(req_of(op, a, i), v, e);
            end else begin
                @(negedge clk);
                check(req_of(op, a, i), {31'b0, irq}, e);
            end
        end

        // R2: transmit strobe in the write cycle
        @(negedge clk);
        bus_addr = 12'h000; bus_wdata = 32'hABCD_EF5A; bus_wr = 1'b1;
        #2 check("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
        check("R2 tx_byte", {24'b0, tx_byte}, 32'h5A);
        @(negedge clk); bus_wr = 1'b0;
        wr(12'h044, 32'h20);

        // R3: receive event, then set against clear in one cycle
        @(negedge clk); rx_evt = 1'b1;
        @(negedge clk); rx_evt = 1'b0;
        rd(12'h03C, v);
        check("R3 rx sets raw", v, 32'h10);
        check("R5 irq from rx", {31'b0, irq}, 32'h1);
        @(negedge clk);
        rx_evt = 1'b1; bus_addr = 12'h044; bus_wdata = 32'h10; bus_wr = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0; bus_wr = 1'b0;
        rd(12'h03C, v);
        check("R3 set beats clear", v, 32'h10);
        wr(12'h044, 32'h7FF);
        rd(12'h03C, v);
        check("R4 clear all", v, 32'h0);
        check("R5 irq drops", {31'b0, irq}, 32'h0);

        // R11: data read pops the receive head
        rx_head = 12'h400;
        @(negedge clk);
        bus_addr = 12'h000; bus_rd = 1'b1;
        #2 check("R11 data read", bus_rdata, 32'h400);
        check("R11 rx_pop", {31'b0, rx_pop}, 32'h1);
        @(negedge clk); bus_rd = 1'b0;

        // R9: unlisted read, then write-protected offsets
        rd(12'h008, v);
        check("R9 unlisted reads zero", v, 32'h0);
        check("R9 err pulse", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        check("R9 err one cycle", {31'b0, bus_err}, 32'h0);
        wr(12'h04C, 32'hFFFF);
        check("R9 err on bad write", {31'b0, bus_err}, 32'h1);
        wr(12'h03C, 32'h7FF);
        check("R9 err on raw write", {31'b0, bus_err}, 32'h1);
        rd(12'h03C, v);
        check("R9 raw unchanged", v, 32'h0);
        rd(12'h038, v);
        check("R9 mask unchanged", v, 32'h30);
        rd(12'h044, v);
        check("R9 clear not readable", v, 32'h0);
        check("R9 err on clear read", {31'b0, bus_err}, 32'h1);

        // R10: DMA enable write
        wr(12'h048, 32'h3);
        check("R10 dma_unsup pulse", {31'b0, dma_unsup}, 32'h1);
        rd(12'h048, v);
        check("R10 dma stored", v, 32'h3);
        check("R10 pulse ends", {31'b0, dma_unsup}, 32'h0);

        // R7: flags load through the status strobe
        @(negedge clk); flag_upd = 1'b1; flag_val = 9'h1A5;
        @(negedge clk); flag_upd = 1'b0;
        rd(12'h018, v);
        check("R7 flags load", v, 32'h1A5);

        // R1: reset in mid-run
        wr(12'h000, 32'h1);
        @(negedge clk);
        check("R5 irq before reset", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq cleared", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(12'h030, v); check("R1 control", v, 32'h300);
        rd(12'h038, v); check("R1 mask", v, 32'h0);
        rd(12'h018, v); check("R1 flags", v, 32'h90);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(1_000_000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule